// File: doc/BRIEF.md
# Single-Word Serial Flash Command Engine

This block runs one short command against a serial NOR flash. Software first loads an address word and up to eight bytes of outgoing data. It then writes a single control word that describes the whole sequence and sets the execute bit in that same word. The sequence is an opcode byte, then an optional address phase, an optional write-data phase and an optional read-data phase. Each byte count is stored as the count minus one.

A byte serializer drives the flash in SPI mode 0 on a single data line. The clock idles low, the outgoing line changes after a falling edge, and the incoming line is sampled on the rising edge. Chip select is held low for the whole sequence. Returned bytes are packed little-endian into two 32-bit result words. While the command runs, an in-progress bit in the control word reads as 1, and software polls it until it clears.

Top module: `flash_cmd_engine`

## Requirements
- R1: Control word (bus address 0): opcode in bits 31:24. After chip select falls, the opcode is the first byte sent. Every byte goes out most significant bit first, 8 clock pulses per byte. The serial clock idles low and its half period is HALF_DIV system cycles.
- R2: Bit 19 enables the address phase, and bits 17:16 give the address byte count minus one. The address comes from bus address 1. Only the low N bytes are used, and they are sent highest byte first.
- R3: Bit 15 enables the write phase, and bits 14:12 give the write byte count minus one. Write bytes are taken least significant byte first from bus address 2 (bytes 0 to 3) and then from bus address 3 (bytes 4 to 7).
- R4: Bit 23 enables the read phase, and bits 22:20 give the read byte count minus one. Read byte k lands in bits 8k+7:8k of bus address 4 for k below 4, and in bits 8(k-4)+7:8(k-4) of bus address 5 otherwise. A command with the read phase enabled first zeroes both result words. A command without it leaves them unchanged. While the data line is being read, the outgoing line is driven low.
- R5: The phases run in the order opcode, address, write, read. Disabled phases are skipped. The total number of bytes is 1 plus the count of every enabled phase.
- R6: Writing the control word with bit 0 set while idle starts the command. From the next cycle, bit 1 of the control word reads 1 and chip select is low.
- R7: Chip select stays low across all bytes and rises after the last falling clock edge. The in-progress bit clears exactly one cycle after chip select rises.
- R8: Any control-word write made while a command is in progress is dropped. The running sequence and the control readback are unchanged.
- R9: After reset, chip select is high, the serial clock and data-out are low, and every register reads zero.
- R10: The control readback returns the written fields in place. Bit 0 reads 0, bit 1 is the in-progress flag, and the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register select (0 control, 1 address, 2/3 write data, 4/5 read data) |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for the selected register |
| sclk_o | output | 1 | Serial clock to the flash |
| cs_no | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
Two situations are hardest to reach from the ports. The first is a control write that lands in the middle of a running command. The bench issues a long read and, a few cycles later, writes a different opcode with execute set. It then compares every byte the flash model saw, and the control readback, against the original command only. The second is the one-cycle gap between chip select rising and the in-progress bit clearing. The bench polls the control word on every cycle while the command runs to catch it. A full eight-byte read followed by a one-byte read shows whether stale upper result bytes survive.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = DATA_W;
  localparam int WDATA_W = 2 * DATA_W;
  localparam int BYTE_W  = 8;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_ADDR = 3'd1;
  localparam logic [2:0] REG_WLO  = 3'd2;
  localparam logic [2:0] REG_WHI  = 3'd3;
  localparam logic [2:0] REG_RLO  = 3'd4;
  localparam logic [2:0] REG_RHI  = 3'd5;

  typedef enum logic [1:0] {PH_OPC, PH_ADR, PH_WR, PH_RD} phase_e;

  typedef struct packed {
    logic [7:0] opc;
    logic       rd_en;
    logic [2:0] rd_m1;
    logic       addr_en;
    logic [1:0] addr_m1;
    logic       wr_en;
    logic [2:0] wr_m1;
  } cmd_t;

  function automatic cmd_t cmd_decode(input logic [DATA_W-1:0] w);
    cmd_t c;
    c.opc     = w[31:24];
    c.rd_en   = w[23];
    c.rd_m1   = w[22:20];
    c.addr_en = w[19];
    c.addr_m1 = w[17:16];
    c.wr_en   = w[15];
    c.wr_m1   = w[14:12];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cmd_encode(input cmd_t c, input logic busy);
    return {c.opc, c.rd_en, c.rd_m1, c.addr_en, 1'b0, c.addr_m1,
            c.wr_en, c.wr_m1, 10'b0, busy, 1'b0};
  endfunction
endpackage

// File: rtl/fce_shifter.sv
module fce_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_DIV - 1);

  logic [HC_W-1:0] hc_q;
  logic [2:0]      bit_q;
  logic            run_q, sclk_q, mosi_q, done_q;
  logic [7:0]      tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q   <= '0;
      bit_q  <= '0;
      run_q  <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (start_i) begin
          run_q  <= 1'b1;
          tx_q   <= byte_i;
          mosi_q <= byte_i[7];
          hc_q   <= '0;
          bit_q  <= '0;
        end
      end else if (hc_q == HC_LAST) begin
        hc_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
            mosi_q <= 1'b0;
          end else begin
            bit_q  <= bit_q + 3'd1;
            tx_q   <= {tx_q[6:0], 1'b0};
            mosi_q <= tx_q[6];
          end
        end
      end else begin
        hc_q <= hc_q + HC_W'(1);
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/fce_regs.sv
module fce_regs
  import fce_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [2:0]         bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  input  logic               busy_i,
  input  logic               rd_we_i,
  input  logic [2:0]         rd_idx_i,
  input  logic [7:0]         rd_byte_i,
  output logic               exec_o,
  output cmd_t               cmd_new_o,
  output cmd_t               ctrl_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [WDATA_W-1:0] wdata_o,
  output logic [WDATA_W-1:0] rdata_o
);
  localparam int NLANE = WDATA_W / BYTE_W;

  cmd_t                ctrl_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wlo_q, whi_q;
  logic                ctrl_wr, clr_rd;

  assign ctrl_wr   = bus_we_i && (bus_addr_i == REG_CTRL);
  assign cmd_new_o = cmd_decode(bus_wdata_i);
  assign exec_o    = ctrl_wr && bus_wdata_i[0] && !busy_i;
  assign clr_rd    = exec_o && cmd_new_o.rd_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      addr_q <= '0;
      wlo_q  <= '0;
      whi_q  <= '0;
    end else begin
      if (ctrl_wr && !busy_i) ctrl_q <= cmd_new_o;
      if (bus_we_i && bus_addr_i == REG_ADDR) addr_q <= bus_wdata_i;
      if (bus_we_i && bus_addr_i == REG_WLO)  wlo_q  <= bus_wdata_i;
      if (bus_we_i && bus_addr_i == REG_WHI)  whi_q  <= bus_wdata_i;
    end
  end

  // one result byte lane per read position
  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                lane_q <= '0;
      else if (clr_rd)                            lane_q <= '0;
      else if (rd_we_i && rd_idx_i == 3'(b))      lane_q <= rd_byte_i;
    end
    assign rdata_o[b*BYTE_W +: BYTE_W] = lane_q;
  end

  assign ctrl_o  = ctrl_q;
  assign addr_o  = addr_q;
  assign wdata_o = {whi_q, wlo_q};
endmodule

// File: rtl/fce_seq.sv
module fce_seq
  import fce_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exec_i,
  input  cmd_t               cmd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [WDATA_W-1:0] wdata_i,
  input  logic               done_i,
  input  logic [7:0]         rx_i,
  output logic               start_o,
  output logic [7:0]         tx_o,
  output logic               cs_no,
  output logic               busy_o,
  output logic               rd_we_o,
  output logic [2:0]         rd_idx_o,
  output logic [7:0]         rd_byte_o
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FIN} state_e;

  state_e              st_q;
  phase_e              ph_q, nxt_ph;
  logic [2:0]          idx_q, ph_last;
  logic                nxt_ok;
  cmd_t                cmd_q;
  logic [ADDR_W-1:0]   addr_q, addr_sh;
  logic [WDATA_W-1:0]  wdata_q, wd_sh;
  logic [1:0]          asel;
  logic                cs_n_q, busy_q;

  always_comb begin
    unique case (ph_q)
      PH_OPC:  ph_last = 3'd0;
      PH_ADR:  ph_last = {1'b0, cmd_q.addr_m1};
      PH_WR:   ph_last = cmd_q.wr_m1;
      default: ph_last = cmd_q.rd_m1;
    endcase
  end

  always_comb begin
    nxt_ok = 1'b1;
    nxt_ph = ph_q;
    unique case (ph_q)
      PH_OPC: begin
        if (cmd_q.addr_en)    nxt_ph = PH_ADR;
        else if (cmd_q.wr_en) nxt_ph = PH_WR;
        else if (cmd_q.rd_en) nxt_ph = PH_RD;
        else                  nxt_ok = 1'b0;
      end
      PH_ADR: begin
        if (cmd_q.wr_en)      nxt_ph = PH_WR;
        else if (cmd_q.rd_en) nxt_ph = PH_RD;
        else                  nxt_ok = 1'b0;
      end
      PH_WR: begin
        if (cmd_q.rd_en)      nxt_ph = PH_RD;
        else                  nxt_ok = 1'b0;
      end
      default:                nxt_ok = 1'b0;
    endcase
  end

  // address leaves high byte first, write data low byte first
  always_comb begin
    asel    = cmd_q.addr_m1 - idx_q[1:0];
    addr_sh = addr_q >> {asel, 3'b000};
    wd_sh   = wdata_q >> {idx_q, 3'b000};
    unique case (ph_q)
      PH_OPC:  tx_o = cmd_q.opc;
      PH_ADR:  tx_o = addr_sh[7:0];
      PH_WR:   tx_o = wd_sh[7:0];
      default: tx_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      ph_q    <= PH_OPC;
      idx_q   <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      cs_n_q  <= 1'b1;
      busy_q  <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (exec_i) begin
          cmd_q   <= cmd_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          ph_q    <= PH_OPC;
          idx_q   <= '0;
          cs_n_q  <= 1'b0;
          busy_q  <= 1'b1;
          st_q    <= S_ISSUE;
        end
        S_ISSUE: st_q <= S_WAIT;
        S_WAIT: if (done_i) begin
          if (idx_q != ph_last) begin
            idx_q <= idx_q + 3'd1;
            st_q  <= S_ISSUE;
          end else if (nxt_ok) begin
            ph_q  <= nxt_ph;
            idx_q <= '0;
            st_q  <= S_ISSUE;
          end else begin
            cs_n_q <= 1'b1;
            st_q   <= S_FIN;
          end
        end
        default: begin
          busy_q <= 1'b0;
          st_q   <= S_IDLE;
        end
      endcase
    end
  end

  assign start_o   = (st_q == S_ISSUE);
  assign cs_no     = cs_n_q;
  assign busy_o    = busy_q;
  assign rd_we_o   = (st_q == S_WAIT) && done_i && (ph_q == PH_RD);
  assign rd_idx_o  = idx_q;
  assign rd_byte_o = rx_i;
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import fce_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  logic               busy, exec, rd_we, start, done;
  logic [2:0]         rd_idx;
  logic [7:0]         rd_byte, tx_byte, rx_byte;
  cmd_t               cmd_new, ctrl;
  logic [ADDR_W-1:0]  addr;
  logic [WDATA_W-1:0] wdata, rdata;

  fce_regs u_regs (
    .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .busy_i   (busy),
    .rd_we_i  (rd_we),
    .rd_idx_i (rd_idx),
    .rd_byte_i(rd_byte),
    .exec_o   (exec),
    .cmd_new_o(cmd_new),
    .ctrl_o   (ctrl),
    .addr_o   (addr),
    .wdata_o  (wdata),
    .rdata_o  (rdata)
  );

  fce_seq u_seq (
    .clk_i, .rst_ni,
    .exec_i   (exec),
    .cmd_i    (cmd_new),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .done_i   (done),
    .rx_i     (rx_byte),
    .start_o  (start),
    .tx_o     (tx_byte),
    .cs_no    (cs_no),
    .busy_o   (busy),
    .rd_we_o  (rd_we),
    .rd_idx_o (rd_idx),
    .rd_byte_o(rd_byte)
  );

  fce_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk_i, .rst_ni,
    .start_i(start),
    .byte_i (tx_byte),
    .miso_i (miso_i),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .done_o (done),
    .rx_o   (rx_byte)
  );

  always_comb begin
    unique case (bus_addr_i)
      REG_CTRL: bus_rdata_o = cmd_encode(ctrl, busy);
      REG_ADDR: bus_rdata_o = addr;
      REG_WLO:  bus_rdata_o = wdata[DATA_W-1:0];
      REG_WHI:  bus_rdata_o = wdata[WDATA_W-1:DATA_W];
      REG_RLO:  bus_rdata_o = rdata[DATA_W-1:0];
      REG_RHI:  bus_rdata_o = rdata[WDATA_W-1:DATA_W];
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/fce_checker.sv
module fce_checker
  import fce_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_we_i,
  input logic [2:0]         bus_addr_i,
  input logic               busy_i,
  input logic               exec_i,
  input logic               cs_n_i,
  input logic               sclk_i,
  input cmd_t               ctrl_i,
  input logic [WDATA_W-1:0] rdata_i
);
  AST_IDLE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> cs_n_i);  // R7
  AST_SCLK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |-> !sclk_i);  // R1
  AST_START_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> (busy_i && !cs_n_i));  // R6
  AST_BUSY_AFTER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_i) |-> (busy_i ##1 !busy_i));  // R7
  AST_CTRL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && bus_we_i && bus_addr_i == REG_CTRL) |=> $stable(ctrl_i));  // R8
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !exec_i) |=> $stable(rdata_i));  // R4
endmodule

bind flash_cmd_engine fce_checker u_fce_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_we_i  (bus_we_i),
  .bus_addr_i(bus_addr_i),
  .busy_i    (busy),
  .exec_i    (exec),
  .cs_n_i    (cs_no),
  .sclk_i    (sclk_o),
  .ctrl_i    (ctrl),
  .rdata_i   (rdata)
);

// File: tb/flash_cmd_engine_test.sv
`timescale 1ns/1ps
module flash_cmd_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, cs_n, mosi;
  logic        miso = 1'b0;

  int checks = 0;
  int fails  = 0;

  flash_cmd_engine #(.HALF_DIV(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .sclk_o(sclk),
    .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  always #4 clk = ~clk;  // 125 MHz

  // flash model
  logic [7:0]  mb [32];
  int          mcnt = 0, bitc = 0, rcnt = 0;
  logic [7:0]  cap = '0, rb;
  logic [7:0]  salt = '0;
  logic [63:0] exp_rd = '0;

  function automatic logic [7:0] resp(input int j);
    return 8'(j * 59 + 165) ^ salt;
  endfunction

  always @(negedge cs_n) begin
    bitc = 0; mcnt = 0; rcnt = 0;
    rb = resp(0);
    miso = rb[7];
  end
  always @(posedge sclk) if (!cs_n) begin
    cap = {cap[6:0], mosi};
    bitc++; rcnt++;
    if (bitc % 8 == 0 && mcnt < 32) begin mb[mcnt] = cap; mcnt++; end
  end
  always @(negedge sclk) if (!cs_n) begin
    rb = resp(bitc / 8);
    miso = rb[7 - (bitc % 8)];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 3'd0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic run_cmd(input logic [7:0] opc, input bit rde, input logic [2:0] rdm,
                         input bit ade, input logic [1:0] adm, input bit wre,
                         input logic [2:0] wrm, input logic [31:0] adr,
                         input logic [63:0] wd, input bit inject);
    logic [7:0]  expb [32];
    logic [31:0] w, rv;
    int          n, j0, guard;
    logic        prev;
    n = 0; j0 = 0;
    salt = 8'($urandom);
    expb[n] = opc; n++;
    if (ade) for (int i = int'(adm); i >= 0; i--) begin expb[n] = adr[8*i +: 8]; n++; end
    if (wre) for (int i = 0; i <= int'(wrm); i++) begin expb[n] = wd[8*i +: 8]; n++; end
    if (rde) begin
      j0 = n;
      exp_rd = '0;
      for (int i = 0; i <= int'(rdm); i++) begin
        expb[n] = 8'h00; n++;
        exp_rd[8*i +: 8] = resp(j0 + i);
      end
    end
    w = {opc, rde, rdm, ade, 1'b0, adm, wre, wrm, 12'h001};
    bus_wr(3'd1, adr);
    bus_wr(3'd2, wd[31:0]);
    bus_wr(3'd3, wd[63:32]);
    bus_wr(3'd0, w);
    #1;
    chk(bus_rdata[1] == 1'b1, "R6", "busy after start", 64'(bus_rdata[1]), 64'd1);
    chk(cs_n == 1'b0, "R6", "cs low after start", 64'(cs_n), 64'd0);
    if (inject) begin
      repeat (5) @(negedge clk);
      bus_wr(3'd0, {~opc, 1'b1, 3'd7, 1'b1, 1'b0, 2'd3, 1'b1, 3'd7, 12'h001});
    end
    bus_addr = 3'd0;
    prev = cs_n;
    guard = 0;
    while (guard < 4000) begin
      @(negedge clk); #1;
      guard++;
      if (prev == 1'b0 && cs_n == 1'b1) begin
        chk(bus_rdata[1] == 1'b1, "R7", "busy when cs rises", 64'(bus_rdata[1]), 64'd1);
        @(negedge clk); #1;
        chk(bus_rdata[1] == 1'b0, "R7", "busy one cycle after cs", 64'(bus_rdata[1]), 64'd0);
        break;
      end
      prev = cs_n;
    end
    if (guard >= 4000) chk(1'b0, "R7", "cs never rose", 64'd0, 64'd1);
    chk(mcnt == n, "R5", "byte count", 64'(mcnt), 64'(n));
    chk(rcnt == 8 * n, "R1", "clock pulses", 64'(rcnt), 64'(8 * n));
    for (int i = 0; i < n && i < mcnt; i++) begin
      if (i == 0)
        chk(mb[i] == expb[i], "R1", "opcode byte", 64'(mb[i]), 64'(expb[i]));
      else if (ade && i <= int'(adm) + 1)
        chk(mb[i] == expb[i], "R2", "address byte", 64'(mb[i]), 64'(expb[i]));
      else if (rde && i >= j0)
        chk(mb[i] == expb[i], "R4", "idle line in read", 64'(mb[i]), 64'(expb[i]));
      else
        chk(mb[i] == expb[i], "R3", "write byte", 64'(mb[i]), 64'(expb[i]));
    end
    bus_rd(3'd4, rv);
    chk(rv == exp_rd[31:0], "R4", "result low", 64'(rv), 64'(exp_rd[31:0]));
    bus_rd(3'd5, rv);
    chk(rv == exp_rd[63:32], "R4", "result high", 64'(rv), 64'(exp_rd[63:32]));
    bus_rd(3'd0, rv);
    if (inject)
      chk(rv == (w & 32'hFFFF_FFFC), "R8", "control after dropped write", 64'(rv), 64'(w & 32'hFFFF_FFFC));
    else
      chk(rv == (w & 32'hFFFF_FFFC), "R10", "control readback", 64'(rv), 64'(w & 32'hFFFF_FFFC));
  endtask

  task automatic run_all();
    logic [31:0] rv;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cs_n == 1'b1, "R9", "reset cs", 64'(cs_n), 64'd1);
    chk(sclk == 1'b0, "R9", "reset sclk", 64'(sclk), 64'd0);
    chk(mosi == 1'b0, "R9", "reset mosi", 64'(mosi), 64'd0);
    for (int a = 0; a < 6; a++) begin
      bus_rd(3'(a), rv);
      chk(rv == 32'd0, "R9", "reset register", 64'(rv), 64'd0);
    end
    // directed corners
    run_cmd(8'h06, 0, 3'd0, 0, 2'd0, 0, 3'd0, 32'h0, 64'h0, 0);
    run_cmd(8'h9F, 1, 3'd7, 0, 2'd0, 0, 3'd0, 32'h0, 64'h0, 0);
    run_cmd(8'h05, 1, 3'd0, 0, 2'd0, 0, 3'd0, 32'h0, 64'h0, 0);
    run_cmd(8'hD8, 0, 3'd0, 1, 2'd3, 0, 3'd0, 32'hA1B2C3D4, 64'h0, 0);
    run_cmd(8'h20, 0, 3'd0, 1, 2'd0, 0, 3'd0, 32'h1234_5678, 64'h0, 0);
    run_cmd(8'h02, 0, 3'd0, 1, 2'd2, 1, 3'd7, 32'h00AB_CDEF, 64'h8877_6655_4433_2211, 0);
    run_cmd(8'h01, 0, 3'd0, 0, 2'd0, 1, 3'd0, 32'h0, 64'h0000_0000_0000_005A, 0);
    run_cmd(8'h0B, 1, 3'd4, 1, 2'd2, 0, 3'd0, 32'h0010_2030, 64'h0, 0);
    run_cmd(8'h4B, 1, 3'd1, 1, 2'd3, 1, 3'd2, 32'hCAFE_F00D, 64'h0000_0000_00C3_B2A1, 0);
    run_cmd(8'h03, 1, 3'd7, 1, 2'd2, 0, 3'd0, 32'h0000_0100, 64'h0, 1);
    // constrained random
    for (int t = 0; t < 30; t++) begin
      run_cmd(8'($urandom), 1'($urandom), 3'($urandom), 1'($urandom), 2'($urandom),
              1'($urandom), 3'($urandom), $urandom, {$urandom, $urandom}, 0);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R5", "watchdog expired", 64'd0, 64'd1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule